// File: doc/BRIEF.md
# External Memory Bus Cycle Controller

This block turns single requests from a small processor core into timed cycles on an external 8-bit memory bus. Each cycle has two phases. In the address phase (T1) the address strobe is high and the address is on the bus. In the data phase (T2) the active-low data strobe is pulled low and data moves. Either phase can be lengthened by 0 to 3 extra clock cycles. Each clock cycle is one phase slot. The core sees a ready flag, a one-cycle completion pulse and the captured read data. All request fields and configuration inputs are latched when a request is accepted, so the core may change them freely during the cycle.

Three options alter the data strobe. In output-enable mode the strobe behaves normally on reads and stays high on writes. In segment-gating mode the strobe is suppressed for a request whose segment bit is 0. The strobe pin can also be released to high impedance, either by a bus grant or by a software request. Accesses marked internal still run through the same phase timing, but no strobe or data driver on the external bus becomes active.

The controller has three states. IDLE accepts a request (IDLE to T1 when `req_i` is high). T1 counts out the address wait states (T1 to T2 when its timer expires). T2 counts out the data wait states (T2 to IDLE when its timer expires, which raises the completion pulse).

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `ds_n_o` is 1, `as_o`, `dq_oe_o` and `done_o` are 0, `ready_o` is 1 and `rdata_o` is 0.
- R2: `ready_o` is 1 exactly in IDLE. A request is accepted only at a clock edge where `ready_o` and `req_i` are both 1. T1 begins on the cycle after acceptance, so a request held high during the completion cycle starts the next T1 right away.
- R3: T1 lasts 1 + `cfg_as_wait_i` cycles, with the value taken at acceptance. `as_o` is 1 throughout T1 for external accesses. `addr_o` shows the accepted address from the first T1 cycle until the next acceptance.
- R4: T2 follows T1 directly and lasts 1 + `cfg_ds_wait_i` cycles. For external accesses with no gating option active, `ds_n_o` is 0 throughout T2 and 1 at all other times.
- R5: For an internal access (`req_ext_i` = 0), `as_o` stays 0, `ds_n_o` stays 1 and `dq_oe_o` stays 0. The phase timing is unchanged and `rdata_o` reports 0.
- R6: On an external read, `dq_oe_o` is 0 from the first T2 cycle onward. `rdata_o` takes the value of `dq_i` sampled at the clock edge that ends T2 and presents it together with `done_o`. Writes and internal accesses report 0.
- R7: On an external write, `dq_oe_o` is 1 and `dq_o` equals the write data from the first T2 cycle until the first T1 cycle of the next access, when `dq_oe_o` returns to 0.
- R8: With `cfg_oe_mode_i` = 1, `ds_n_o` stays 1 for the whole of an external write and acts as in R4 on external reads.
- R9: With `cfg_seg_gate_i` = 1 and `req_seg_i` = 0, `ds_n_o` stays 1 for the whole access. With `req_seg_i` = 1 the strobe follows R4 and R8.
- R10: `ds_hiz_o` equals `bus_grant_i` OR `soft_hiz_i` at all times, combinationally.
- R11: `done_o` is high for exactly one cycle, the cycle after the last T2 cycle (the cycle after the data strobe rises).
- R12: Changing any request or configuration input after acceptance has no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request valid |
| req_ext_i | input | 1 | 1 = external access, 0 = internal |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | 8 | Write data |
| req_seg_i | input | 1 | Segment select bit of the request |
| cfg_as_wait_i | input | 2 | Extra T1 cycles, 0 to 3 |
| cfg_ds_wait_i | input | 2 | Extra T2 cycles, 0 to 3 |
| cfg_oe_mode_i | input | 1 | Data strobe acts as output enable |
| cfg_seg_gate_i | input | 1 | Segment gating of the data strobe |
| bus_grant_i | input | 1 | Bus granted away, release strobe |
| soft_hiz_i | input | 1 | Software release of the strobe |
| ready_o | output | 1 | Controller idle, request may be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data of the finished access |
| addr_o | output | ADDR_W | Bus address |
| as_o | output | 1 | Address strobe, active high |
| ds_n_o | output | 1 | Data strobe, active low |
| ds_hiz_o | output | 1 | Data strobe pin released |
| dq_o | output | 8 | Data bus output value |
| dq_oe_o | output | 1 | Data bus output enable |
| dq_i | input | 8 | Data bus input value |

## Verification
After an acceptance edge, T1 starts on the next cycle. T2 starts `cfg_as_wait_i` + 1 cycles later, and `done_o` and `rdata_o` arrive `cfg_ds_wait_i` + 1 cycles after that. `ds_hiz_o` follows its inputs within the same cycle. The bench model turns each acceptance into absolute cycle numbers for the T1, T2 and completion windows. Every clock it compares each output with the value due in that cycle, sampling a quarter period after the rising edge while the inputs change on the falling edge.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_T2   = 2'd2
    } xbus_state_e;

endpackage

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/xbus_strobe_map.sv
module xbus_strobe_map (
    input  logic t2_i,
    input  logic ext_i,
    input  logic we_i,
    input  logic oe_mode_i,
    input  logic seg_gate_i,
    input  logic seg_sel_i,
    input  logic grant_i,
    input  logic soft_hiz_i,
    output logic ds_n_o,
    output logic ds_hiz_o
);

    logic blocked;

    always_comb begin
        blocked  = (oe_mode_i && we_i) || (seg_gate_i && !seg_sel_i);
        ds_n_o   = !(t2_i && ext_i && !blocked);
        ds_hiz_o = grant_i || soft_hiz_i;
    end

endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_ext_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              req_seg_i,
    input  logic [WAIT_W-1:0] cfg_as_wait_i,
    input  logic [WAIT_W-1:0] cfg_ds_wait_i,
    input  logic              cfg_oe_mode_i,
    input  logic              cfg_seg_gate_i,
    input  logic              bus_grant_i,
    input  logic              soft_hiz_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              as_o,
    output logic              ds_n_o,
    output logic              ds_hiz_o,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    input  logic [DATA_W-1:0] dq_i
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ext;
        logic              we;
        logic              seg;
        logic              oe_mode;
        logic              seg_gate;
        logic [WAIT_W-1:0] ds_wait;
    } held_req_t;

    xbus_state_e       state_q, state_d;
    held_req_t         req_q;
    logic              accept, t1_end, t2_end, expire;
    logic              tmr_load;
    logic [WAIT_W-1:0] tmr_val;
    logic              done_q, oe_q;
    logic [DATA_W-1:0] rdata_q, dout_q;

    assign accept = (state_q == ST_IDLE) && req_i;
    assign t1_end = (state_q == ST_T1) && expire;
    assign t2_end = (state_q == ST_T2) && expire;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i)  state_d = ST_T1;
            ST_T1:   if (expire) state_d = ST_T2;
            ST_T2:   if (expire) state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    // Phase timer: loaded at acceptance with the T1 extension, at T1 end with the T2 extension
    assign tmr_load = accept || t1_end;
    assign tmr_val  = accept ? cfg_as_wait_i : req_q.ds_wait;

    xbus_phase_timer #(.CNT_W(WAIT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (expire)
    );

    // Request capture, data path and completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= '0;
            done_q  <= 1'b0;
            oe_q    <= 1'b0;
            rdata_q <= '0;
            dout_q  <= '0;
        end else begin
            done_q <= t2_end;
            if (accept) begin
                req_q.addr     <= req_addr_i;
                req_q.wdata    <= req_wdata_i;
                req_q.ext      <= req_ext_i;
                req_q.we       <= req_we_i;
                req_q.seg      <= req_seg_i;
                req_q.oe_mode  <= cfg_oe_mode_i;
                req_q.seg_gate <= cfg_seg_gate_i;
                req_q.ds_wait  <= cfg_ds_wait_i;
                oe_q           <= 1'b0;
            end
            if (t1_end) begin
                oe_q <= req_q.ext && req_q.we;
                if (req_q.ext && req_q.we) dout_q <= req_q.wdata;
            end
            if (t2_end) begin
                rdata_q <= (req_q.ext && !req_q.we) ? dq_i : '0;
            end
        end
    end

    // Outputs
    always_comb begin
        ready_o = (state_q == ST_IDLE);
        as_o    = (state_q == ST_T1) && req_q.ext;
        done_o  = done_q;
        rdata_o = rdata_q;
        addr_o  = req_q.addr;
        dq_o    = dout_q;
        dq_oe_o = oe_q;
    end

    xbus_strobe_map u_strobe (
        .t2_i       (state_q == ST_T2),
        .ext_i      (req_q.ext),
        .we_i       (req_q.we),
        .oe_mode_i  (req_q.oe_mode),
        .seg_gate_i (req_q.seg_gate),
        .seg_sel_i  (req_q.seg),
        .grant_i    (bus_grant_i),
        .soft_hiz_i (soft_hiz_i),
        .ds_n_o     (ds_n_o),
        .ds_hiz_o   (ds_hiz_o)
    );

    // Assertions
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r11_done_after_t2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state_q == ST_T2));

    a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T2 && !req_q.we) |-> !dq_oe_o);

    a_r7_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_o && $past(dq_oe_o)) |-> $stable(dq_o));

    a_r4_ds_only_t2: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n_o |-> (state_q == ST_T2 && req_q.ext));

    a_r2_no_skip_back: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T2) |=> (state_q != ST_T1));

endmodule

// File: tb/tb_xbus_cycle_ctrl.sv
module tb_xbus_cycle_ctrl;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0, req_ext_i = 1'b0, req_we_i = 1'b0, req_seg_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [7:0]    req_wdata_i = '0;
    logic [1:0]    cfg_as_wait_i = '0, cfg_ds_wait_i = '0;
    logic          cfg_oe_mode_i = 1'b0, cfg_seg_gate_i = 1'b0;
    logic          bus_grant_i = 1'b0, soft_hiz_i = 1'b0;
    logic          ready_o, done_o, as_o, ds_n_o, ds_hiz_o, dq_oe_o;
    logic [7:0]    rdata_o, dq_o, dq_i;
    logic [AW-1:0] addr_o;

    always #10 clk = ~clk;

    assign dq_i = addr_o[7:0] ^ 8'hA5;

    xbus_cycle_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_ext_i(req_ext_i), .req_we_i(req_we_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_seg_i(req_seg_i),
        .cfg_as_wait_i(cfg_as_wait_i), .cfg_ds_wait_i(cfg_ds_wait_i),
        .cfg_oe_mode_i(cfg_oe_mode_i), .cfg_seg_gate_i(cfg_seg_gate_i),
        .bus_grant_i(bus_grant_i), .soft_hiz_i(soft_hiz_i),
        .ready_o(ready_o), .done_o(done_o), .rdata_o(rdata_o), .addr_o(addr_o),
        .as_o(as_o), .ds_n_o(ds_n_o), .ds_hiz_o(ds_hiz_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
        .dq_i(dq_i)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Behavioural timeline model
    int          cyc = 0, k0 = -100, m_asw = 0, m_dsw = 0;
    bit          mv = 0, m_ext = 0, m_we = 0, m_seg = 0, m_mc = 0, m_sg = 0;
    logic [7:0]  m_wd = '0, e_dq = '0, e_rd = '0;
    logic [AW-1:0] e_addr = '0;
    bit          e_oe = 0;

    function automatic int phase(int c);
        if (!mv) return 0;
        if (c >= k0 && c <= k0 + m_asw) return 1;
        if (c > k0 + m_asw && c <= k0 + m_asw + m_dsw + 1) return 2;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc = 0; mv = 0; e_oe = 0; e_dq = '0; e_rd = '0; e_addr = '0;
        end else begin
            if (phase(cyc) == 0 && req_i) begin
                k0 = cyc + 1; mv = 1;
                m_ext = req_ext_i; m_we = req_we_i; m_seg = req_seg_i;
                m_mc = cfg_oe_mode_i; m_sg = cfg_seg_gate_i;
                m_asw = int'(cfg_as_wait_i); m_dsw = int'(cfg_ds_wait_i);
                m_wd = req_wdata_i; e_addr = req_addr_i; e_oe = 0;
            end
            cyc = cyc + 1;
            if (mv && cyc == k0 + m_asw + 1) begin
                e_oe = m_ext && m_we;
                if (e_oe) e_dq = m_wd;
            end
            if (mv && cyc == k0 + m_asw + m_dsw + 2)
                e_rd = (m_ext && !m_we) ? (e_addr[7:0] ^ 8'hA5) : 8'h00;
        end
    end

    // Per-cycle comparison a quarter period after the rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            int p;
            bit dn, ds_exp;
            string ds_tag;
            p  = phase(cyc);
            dn = mv && (cyc == k0 + m_asw + m_dsw + 2);
            ds_exp = !(p == 2 && m_ext && !(m_mc && m_we) && !(m_sg && !m_seg));
            if (!m_ext)               ds_tag = "R5";
            else if (m_sg && !m_seg)  ds_tag = "R9";
            else if (m_mc && m_we)    ds_tag = "R8";
            else                      ds_tag = "R4";
            chk("R2 ready", {31'd0, ready_o}, {31'd0, p == 0});
            chk("R3 as", {31'd0, as_o}, {31'd0, p == 1 && m_ext});
            chk("R3 addr", {16'd0, addr_o}, {16'd0, e_addr});
            chk(ds_tag, {31'd0, ds_n_o}, {31'd0, ds_exp});
            chk("R7 oe", {31'd0, dq_oe_o}, {31'd0, e_oe});
            if (e_oe) chk("R7 dq", {24'd0, dq_o}, {24'd0, e_dq});
            chk("R11 done", {31'd0, done_o}, {31'd0, dn});
            if (dn) chk("R6 rdata", {24'd0, rdata_o}, {24'd0, e_rd});
            chk("R10 hiz", {31'd0, ds_hiz_o}, {31'd0, bus_grant_i | soft_hiz_i});
        end
    end

    task automatic access(input bit ext, input bit we, input logic [AW-1:0] a,
                          input logic [7:0] wd, input bit seg, input int asw, input int dsw,
                          input bit mc, input bit sg);
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        req_ext_i = ext; req_we_i = we; req_addr_i = a; req_wdata_i = wd; req_seg_i = seg;
        cfg_as_wait_i = 2'(asw); cfg_ds_wait_i = 2'(dsw);
        cfg_oe_mode_i = mc; cfg_seg_gate_i = sg;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(64'd4_000_000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ds_n", {31'd0, ds_n_o}, 32'd1);
        chk("R1 as", {31'd0, as_o}, 32'd0);
        chk("R1 oe", {31'd0, dq_oe_o}, 32'd0);
        chk("R1 done", {31'd0, done_o}, 32'd0);
        chk("R1 ready", {31'd0, ready_o}, 32'd1);
        chk("R1 rdata", {24'd0, rdata_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ds_n after", {31'd0, ds_n_o}, 32'd1);

        // R3 R4 R6 basic external read, no waits
        access(1, 0, 16'h1234, 8'h00, 1, 0, 0, 0, 0);
        wait_idle();
        // R7 write with waits, then a read releasing the bus
        access(1, 1, 16'h2001, 8'h3C, 1, 1, 2, 0, 0);
        wait_idle();
        access(1, 0, 16'h2002, 8'h00, 1, 3, 1, 0, 0);
        wait_idle();
        // R5 internal accesses with maximum waits
        access(0, 1, 16'h0010, 8'h77, 1, 3, 3, 0, 0);
        access(0, 0, 16'h0011, 8'h00, 1, 3, 3, 0, 0);
        wait_idle();
        // R8 output-enable mode
        access(1, 1, 16'h3003, 8'h5A, 1, 0, 1, 1, 0);
        access(1, 0, 16'h3004, 8'h00, 1, 0, 1, 1, 0);
        wait_idle();
        // R9 segment gating
        access(1, 0, 16'h4005, 8'h00, 0, 1, 0, 0, 1);
        access(1, 0, 16'h4006, 8'h00, 1, 1, 0, 0, 1);
        access(1, 1, 16'h4007, 8'hC3, 0, 2, 2, 0, 1);
        wait_idle();
        // R12 inputs changed during the access
        access(1, 0, 16'h5008, 8'h00, 1, 2, 2, 0, 0);
        req_addr_i = 16'hFFFF; req_we_i = 1'b1; req_ext_i = 1'b0;
        cfg_as_wait_i = 2'd0; cfg_ds_wait_i = 2'd0; cfg_oe_mode_i = 1'b1; cfg_seg_gate_i = 1'b1;
        req_seg_i = 1'b0;
        wait_idle();
        chk("R12 rdata latched", {24'd0, rdata_o}, {24'd0, 8'h08 ^ 8'hA5});
        chk("R12 addr latched", {16'd0, addr_o}, 32'h5008);
        // R2 back-to-back with request held high
        @(negedge clk);
        req_ext_i = 1'b1; req_we_i = 1'b0; req_addr_i = 16'h6009; req_seg_i = 1'b1;
        cfg_as_wait_i = 2'd1; cfg_ds_wait_i = 2'd0; cfg_oe_mode_i = 1'b0; cfg_seg_gate_i = 1'b0;
        req_i = 1'b1;
        repeat (14) @(negedge clk);
        req_i = 1'b0;
        wait_idle();
        // R10 strobe release
        bus_grant_i = 1'b1;
        access(1, 0, 16'h700A, 8'h00, 1, 0, 0, 0, 0);
        soft_hiz_i = 1'b1; bus_grant_i = 1'b0;
        wait_idle();
        soft_hiz_i = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule